// File: doc/BRIEF.md
# Reference-Counted Clock Gate Tree

This block keeps the gate-enable bits for a fixed tree of clock nodes. Every node has a use count, an optional parent, and an optional gate bit in one of several gate registers. A client asks for one node at a time to be enabled or disabled. The block then adjusts the use counts along the path to the root. It changes a gate bit only when a count moves between zero and one. It walks toward the root so that a parent always runs before its child is switched on, and a child is always stopped before its parent is switched off.

Some gate registers are protected. A change to a bit in a protected register must follow an unlock cycle, in which the block pulses `unlockPulse` and then performs the data write on the next cycle. The datapath drops a write to a protected register that was not armed by an unlock. A request is accepted only while the block is idle. `busy` covers the whole walk, and a single-cycle `done` closes it. `err` is reported together with `done` when the request was rejected.

The tree topology is set by parameters. These are the parent index, the has-parent and has-register flags, the register select and the bit position of each node, plus a protection flag for each register.

Top module: `refcnt_gate_tree`

## Requirements
- R1: After reset every gate bit is 0, `busy` and `done` are 0, and every use count is zero, so a disable to any valid node is rejected.
- R2: An enable (`reqEnable`=1) adds one to the node's count, and a disable (`reqEnable`=0) removes one. A node's gate bit is 1 exactly while its count is above zero.
- R3: An enable that moves a node from zero first processes its parent (recursively). An ancestor's gate bit therefore rises in an earlier cycle than the child's.
- R4: A disable that moves a node to zero clears the node's own gate bit before it touches the parent. A child's gate bit therefore falls in an earlier cycle than its ancestor's.
- R5: A node without a gate register changes only its count. A node without a parent ends the walk.
- R6: Each gate-bit change in a protected register is preceded by exactly one `unlockPulse`, and the data write follows on the next cycle. Unprotected registers never use an unlock.
- R7: A request with `reqNode` ≥ NUM_NODES is rejected: `err` is raised with `done`, and no count or gate bit changes.
- R8: A disable on a node whose count is zero is rejected with `err`. The count stays at zero and does not wrap.
- R9: `busy` is high from the cycle after acceptance until `done`. `done` lasts one cycle, and `err` is only high while `done` is high.
- R10: `reqValid` is ignored while `busy` is high.
- R11: The default tree has these parents: node 0 is the root, 1→0, 2→1, 3→2, 4→2, 5→0, 6→0, 7→1. Nodes 0 and 1 have no gate register. The gate bits are `gateBits` index 0, 1, 2, 8, 9, 10 for nodes 2 to 7. Register 1 (bits 15:8) is protected, and register 0 (bits 7:0) is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqEnable | input | 1 | 1 = enable, 0 = disable |
| reqNode | input | NODE_W+1 | Node index; values ≥ NUM_NODES are invalid |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request rejected (valid only with done) |
| gateBits | output | NUM_REGS*REG_W | All gate registers, register r at bits r*REG_W upward |
| unlockPulse | output | 1 | Unlock-key write strobe |
| regWrite | output | 1 | Gate-register data write strobe |
| regWriteSel | output | RSEL_W | Register addressed by the data write |

## Verification
The hardest situation to reach from the ports is a walk that spans several levels in both directions. One example is a disable that drops a grandchild, its parent and a register-less grandparent to zero in one request. This only happens when the counts on the whole path are exactly one, which random traffic rarely leaves behind. Directed sequences build these chains from a clean reset and time-stamp each gate edge to check the ordering. A constrained random run with invalid indices and zero-count disables then pushes the counts to varied depths. The same stimulus also drives a request while a four-level enable is still running.

// File: rtl/refcnt_gate_pkg.sv
package refcnt_gate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP,
    ST_ESTEP,
    ST_KEY,
    ST_WRITE,
    ST_DSTEP,
    ST_FINISH
  } walk_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture request node and direction
    logic push;    // push current node onto path stack
    logic climb;   // current <- parent(current)
    logic pop;     // current <- stack top
    logic incr;    // count(current) + 1
    logic decr;    // count(current) - 1
    logic keyWr;   // unlock-key write
    logic dataWr;  // gate register read-modify-write
    logic setErr;
    logic clrErr;
  } walk_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic reqOk;
    logic reqCntZero;
    logic curCntZero;
    logic curCntOne;
    logic curHasParent;
    logic curHasReg;
    logic curLocked;
    logic stackEmpty;
    logic opEn;
  } walk_status_t;

endpackage

// File: rtl/refcnt_gate_ctrl.sv
module refcnt_gate_ctrl
  import refcnt_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqEnable,
  input  walk_status_t st,
  output walk_strobe_t stb,
  output logic         busy,
  output logic         done,
  output logic         err
);

  walk_state_t state, nxt;
  logic errReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      errReg <= 1'b0;
    end else begin
      state <= nxt;
      if (stb.setErr)      errReg <= 1'b1;
      else if (stb.clrErr) errReg <= 1'b0;
    end
  end

  always_comb begin
    stb = '0;
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (!st.reqOk || (!reqEnable && st.reqCntZero)) begin
            stb.setErr = 1'b1;
            nxt        = ST_FINISH;
          end else begin
            stb.load   = 1'b1;
            stb.clrErr = 1'b1;
            nxt        = reqEnable ? ST_PUSH : ST_DSTEP;
          end
        end
      end
      ST_PUSH: begin
        // record the path until a running node or the root is reached
        stb.push = 1'b1;
        if (st.curCntZero && st.curHasParent) stb.climb = 1'b1;
        else                                  nxt = ST_POP;
      end
      ST_POP: begin
        stb.pop = 1'b1;
        nxt     = ST_ESTEP;
      end
      ST_ESTEP: begin
        stb.incr = 1'b1;
        if (st.curCntZero && st.curHasReg) nxt = st.curLocked ? ST_KEY : ST_WRITE;
        else if (st.stackEmpty)            nxt = ST_FINISH;
        else                               nxt = ST_POP;
      end
      ST_KEY: begin
        stb.keyWr = 1'b1;
        nxt       = ST_WRITE;
      end
      ST_WRITE: begin
        stb.dataWr = 1'b1;
        if (st.opEn) begin
          nxt = st.stackEmpty ? ST_FINISH : ST_POP;
        end else if (st.curHasParent) begin
          stb.climb = 1'b1;
          nxt       = ST_DSTEP;
        end else begin
          nxt = ST_FINISH;
        end
      end
      ST_DSTEP: begin
        stb.decr = 1'b1;
        if (st.curCntOne) begin
          if (st.curHasReg)         nxt = st.curLocked ? ST_KEY : ST_WRITE;
          else if (st.curHasParent) stb.climb = 1'b1;
          else                      nxt = ST_FINISH;
        end else begin
          nxt = ST_FINISH;
        end
      end
      ST_FINISH: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);
  assign err  = done && errReg;

endmodule

// File: rtl/refcnt_gate_dpath.sv
module refcnt_gate_dpath
  import refcnt_gate_pkg::*;
#(
  parameter int NUM_NODES = 8,
  parameter int NUM_REGS  = 2,
  parameter int REG_W     = 8,
  parameter int CNT_W     = 6,
  parameter int MAX_DEPTH = 4,
  parameter int NODE_W    = $clog2(NUM_NODES),
  parameter int RSEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  parameter int BIT_W     = $clog2(REG_W),
  parameter logic [NUM_NODES*NODE_W-1:0] NODE_PARENT     = '0,
  parameter logic [NUM_NODES-1:0]        NODE_HAS_PARENT = '0,
  parameter logic [NUM_NODES-1:0]        NODE_HAS_REG    = '0,
  parameter logic [NUM_NODES*RSEL_W-1:0] NODE_REG        = '0,
  parameter logic [NUM_NODES*BIT_W-1:0]  NODE_BIT        = '0,
  parameter logic [NUM_REGS-1:0]         REG_PROTECTED   = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  walk_strobe_t               stb,
  input  logic [NODE_W:0]            reqNode,
  input  logic                       reqEnable,
  output walk_status_t               st,
  output logic [NUM_REGS*REG_W-1:0]  gateBits,
  output logic                       unlockPulse,
  output logic                       regWrite,
  output logic [RSEL_W-1:0]          regWriteSel
);

  localparam int SP_W  = $clog2(MAX_DEPTH + 1);
  localparam int STK_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;

  logic [NODE_W-1:0] cur;
  logic              opEn;
  logic [CNT_W-1:0]  cnt   [NUM_NODES];
  logic [NODE_W-1:0] stack [MAX_DEPTH];
  logic [SP_W-1:0]   sp;
  logic [SP_W-1:0]   spDec;
  logic [REG_W-1:0]  gateReg [NUM_REGS];
  logic              unlockArmed;

  // per-node attributes of the current node
  logic [NODE_W-1:0] curParent;
  logic [RSEL_W-1:0] curReg;
  logic [BIT_W-1:0]  curBit;
  logic [REG_W-1:0]  curMask;
  logic [CNT_W-1:0]  curCnt;
  logic [NODE_W-1:0] reqIdx;
  logic              writeAllowed;

  assign curParent = NODE_PARENT[cur*NODE_W +: NODE_W];
  assign curReg    = NODE_REG[cur*RSEL_W +: RSEL_W];
  assign curBit    = NODE_BIT[cur*BIT_W +: BIT_W];
  assign curMask   = REG_W'(1) << curBit;
  assign curCnt    = cnt[cur];
  assign reqIdx    = reqNode[NODE_W-1:0];
  assign spDec     = sp - 1'b1;

  always_comb begin
    st              = '0;
    st.reqOk        = (reqNode < (NODE_W+1)'(NUM_NODES));
    st.reqCntZero   = (cnt[reqIdx] == '0);
    st.curCntZero   = (curCnt == '0);
    st.curCntOne    = (curCnt == CNT_W'(1));
    st.curHasParent = NODE_HAS_PARENT[cur];
    st.curHasReg    = NODE_HAS_REG[cur];
    st.curLocked    = REG_PROTECTED[curReg];
    st.stackEmpty   = (sp == '0);
    st.opEn         = opEn;
  end

  // current node, direction and path stack pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur  <= '0;
      opEn <= 1'b0;
      sp   <= '0;
    end else begin
      if (stb.load) begin
        cur  <= reqIdx;
        opEn <= reqEnable;
      end else if (stb.climb) begin
        cur <= curParent;
      end else if (stb.pop) begin
        cur <= stack[spDec[STK_W-1:0]];
      end
      if (stb.push)     sp <= sp + 1'b1;
      else if (stb.pop) sp <= spDec;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push) stack[sp[STK_W-1:0]] <= cur;
  end

  // use counters, one per node
  for (genvar g = 0; g < NUM_NODES; g++) begin : g_count
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    cnt[g] <= '0;
      else if (stb.incr && cur == NODE_W'(g))       cnt[g] <= cnt[g] + 1'b1;
      else if (stb.decr && cur == NODE_W'(g))       cnt[g] <= cnt[g] - 1'b1;
    end
  end

  // protected-write arming: valid for the single cycle after the key
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) unlockArmed <= 1'b0;
    else       unlockArmed <= stb.keyWr;
  end

  assign writeAllowed = !REG_PROTECTED[curReg] || unlockArmed;

  // gate registers with read-modify-write update
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_gate
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gateReg[r] <= '0;
      end else if (stb.dataWr && writeAllowed && curReg == RSEL_W'(r)) begin
        if (opEn) gateReg[r] <= gateReg[r] | curMask;
        else      gateReg[r] <= gateReg[r] & ~curMask;
      end
    end
    assign gateBits[r*REG_W +: REG_W] = gateReg[r];
  end

  assign unlockPulse = stb.keyWr;
  assign regWrite    = stb.dataWr;
  assign regWriteSel = curReg;

endmodule

// File: rtl/refcnt_gate_tree.sv
module refcnt_gate_tree
  import refcnt_gate_pkg::*;
#(
  parameter int NUM_NODES = 8,
  parameter int NUM_REGS  = 2,
  parameter int REG_W     = 8,
  parameter int CNT_W     = 6,
  parameter int MAX_DEPTH = 4,
  parameter int NODE_W    = $clog2(NUM_NODES),
  parameter int RSEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  parameter int BIT_W     = $clog2(REG_W),
  parameter logic [NUM_NODES*NODE_W-1:0] NODE_PARENT =
    {3'd1, 3'd0, 3'd0, 3'd2, 3'd2, 3'd1, 3'd0, 3'd0},
  parameter logic [NUM_NODES-1:0] NODE_HAS_PARENT = 8'b1111_1110,
  parameter logic [NUM_NODES-1:0] NODE_HAS_REG    = 8'b1111_1100,
  parameter logic [NUM_NODES*RSEL_W-1:0] NODE_REG = 8'b1110_0000,
  parameter logic [NUM_NODES*BIT_W-1:0] NODE_BIT =
    {3'd2, 3'd1, 3'd0, 3'd2, 3'd1, 3'd0, 3'd0, 3'd0},
  parameter logic [NUM_REGS-1:0] REG_PROTECTED = 2'b10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqEnable,
  input  logic [NODE_W:0]           reqNode,
  output logic                      busy,
  output logic                      done,
  output logic                      err,
  output logic [NUM_REGS*REG_W-1:0] gateBits,
  output logic                      unlockPulse,
  output logic                      regWrite,
  output logic [RSEL_W-1:0]         regWriteSel
);

  walk_strobe_t stb;
  walk_status_t st;

  refcnt_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEnable(reqEnable),
    .st(st), .stb(stb), .busy(busy), .done(done), .err(err)
  );

  refcnt_gate_dpath #(
    .NUM_NODES(NUM_NODES), .NUM_REGS(NUM_REGS), .REG_W(REG_W),
    .CNT_W(CNT_W), .MAX_DEPTH(MAX_DEPTH), .NODE_W(NODE_W),
    .RSEL_W(RSEL_W), .BIT_W(BIT_W), .NODE_PARENT(NODE_PARENT),
    .NODE_HAS_PARENT(NODE_HAS_PARENT), .NODE_HAS_REG(NODE_HAS_REG),
    .NODE_REG(NODE_REG), .NODE_BIT(NODE_BIT), .REG_PROTECTED(REG_PROTECTED)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqNode(reqNode),
    .reqEnable(reqEnable), .st(st), .gateBits(gateBits),
    .unlockPulse(unlockPulse), .regWrite(regWrite), .regWriteSel(regWriteSel)
  );

endmodule

// File: rtl/refcnt_gate_checker.sv
module refcnt_gate_checker #(
  parameter int NUM_REGS = 2,
  parameter int REG_W    = 8,
  parameter int RSEL_W   = 1,
  parameter logic [NUM_REGS-1:0] REG_PROTECTED = '0
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      reqValid,
  input logic                      busy,
  input logic                      done,
  input logic                      err,
  input logic [NUM_REGS*REG_W-1:0] gateBits,
  input logic                      unlockPulse,
  input logic                      regWrite,
  input logic [RSEL_W-1:0]         regWriteSel
);

  logic [NUM_REGS*REG_W-1:0] protMask;
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_mask
    assign protMask[r*REG_W +: REG_W] = {REG_W{REG_PROTECTED[r]}};
  end

  // R6: protected gate bits change only two cycles after an unlock key
  assert_protected_after_key_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gateBits & protMask) |-> $past(unlockPulse, 2));

  // R6: a data write to a protected register directly follows a key
  assert_write_follows_key_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && REG_PROTECTED[regWriteSel]) |-> $past(unlockPulse));

  // R6: every key is followed by a data write
  assert_key_then_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    unlockPulse |=> regWrite);

  // R9: done is a single-cycle pulse
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: err only accompanies done
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  // R9: an idle request is accepted and raises busy
  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  // R10: gate bits never move unless a walk was running
  assert_gate_needs_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gateBits) |-> $past(busy));

endmodule

bind refcnt_gate_tree refcnt_gate_checker #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .RSEL_W(RSEL_W), .REG_PROTECTED(REG_PROTECTED)
) u_gateChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .done(done),
  .err(err), .gateBits(gateBits), .unlockPulse(unlockPulse),
  .regWrite(regWrite), .regWriteSel(regWriteSel)
);

// File: tb/refcnt_gate_tree_bench.sv
module refcnt_gate_tree_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqEnable = 1'b0;
  logic [3:0]  reqNode = '0;
  logic        busy, done, err;
  logic [15:0] gateBits;
  logic        unlockPulse, regWrite;
  logic [0:0]  regWriteSel;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  int unlockSeen = 0;
  int riseAt [8];
  int fallAt [8];
  int mcnt [8];
  logic [15:0] prevG = '0;

  always #10 clk = ~clk;

  refcnt_gate_tree u_refcnt_gate_tree (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEnable(reqEnable),
    .reqNode(reqNode), .busy(busy), .done(done), .err(err),
    .gateBits(gateBits), .unlockPulse(unlockPulse), .regWrite(regWrite),
    .regWriteSel(regWriteSel)
  );

  // R11 default topology, rebuilt independently
  function automatic int parentOf(int n);
    case (n)
      1, 5, 6: return 0;
      2, 7:    return 1;
      3, 4:    return 2;
      default: return 0;
    endcase
  endfunction
  function automatic bit hasPar(int n);    return n != 0; endfunction
  function automatic bit hasReg(int n);    return n >= 2; endfunction
  function automatic bit isLocked(int n);  return n >= 5; endfunction
  function automatic int gbit(int n);      return (n < 5) ? n - 2 : n + 3; endfunction

  function automatic logic [15:0] expGates();
    logic [15:0] v = '0;
    for (int n = 2; n < 8; n++) if (mcnt[n] > 0) v[gbit(n)] = 1'b1;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    for (int n = 2; n < 8; n++) begin
      if (gateBits[gbit(n)] && !prevG[gbit(n)]) riseAt[n] = cyc;
      if (!gateBits[gbit(n)] && prevG[gbit(n)]) fallAt[n] = cyc;
    end
    if (unlockPulse) unlockSeen++;
    prevG = gateBits;
  end

  // reference model of one request
  task automatic modelOp(input bit en, input int n, output bit e, output int u);
    int c;
    e = 0; u = 0;
    if (n >= 8)                 begin e = 1; return; end
    if (!en && mcnt[n] == 0)    begin e = 1; return; end
    c = n;
    forever begin
      if (en) begin
        mcnt[c]++;
        if (mcnt[c] != 1) break;
      end else begin
        mcnt[c]--;
        if (mcnt[c] != 0) break;
      end
      if (hasReg(c) && isLocked(c)) u++;
      if (!hasPar(c)) break;
      c = parentOf(c);
    end
  endtask

  task automatic startReq(input bit en, input int n);
    for (int i = 0; i < 8; i++) begin riseAt[i] = -1; fallAt[i] = -1; end
    unlockSeen = 0;
    reqEnable = en;
    reqNode = 4'(n);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) check(0, {tag, " timeout"}, 0, 1);
  endtask

  task automatic doOp(input bit en, input int n, input string tag);
    bit e; int u; bit gotErr;
    modelOp(en, n, e, u);
    startReq(en, n);
    waitDone(tag);
    gotErr = err;
    check(gotErr == e, {tag, " err"}, gotErr, e);
    @(negedge clk);
    check(done == 1'b0, "R9 done single pulse", done, 0);
    check(gateBits == expGates(), {tag, " gates"}, gateBits, expGates());
    check(unlockSeen == u, "R6 unlock count", unlockSeen, u);
    if (en) begin
      for (int c = 3; c <= 4; c++)
        if (riseAt[c] >= 0 && riseAt[2] >= 0)
          check(riseAt[2] < riseAt[c], "R3 parent before child", riseAt[2], riseAt[c]);
    end else begin
      for (int c = 3; c <= 4; c++)
        if (fallAt[c] >= 0 && fallAt[2] >= 0)
          check(fallAt[c] < fallAt[2], "R4 child before parent", fallAt[c], fallAt[2]);
    end
  endtask

  initial begin
    #(200000 * 20);
    check(0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 8; i++) mcnt[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(gateBits == 16'h0, "R1 reset gates", gateBits, 0);
    check(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", {busy, done}, 0);

    // R10: second request while a four-level enable walk runs
    begin
      bit e; int u;
      modelOp(1, 3, e, u);
      startReq(1, 3);
      check(busy == 1'b1, "R9 busy after accept", busy, 1);
      reqEnable = 1'b1; reqNode = 4'd7; reqValid = 1'b1;
      @(negedge clk); @(negedge clk);
      reqValid = 1'b0;
      waitDone("R10");
      @(negedge clk);
      check(gateBits == expGates(), "R10 busy request ignored", gateBits, expGates());
      check(riseAt[2] >= 0 && riseAt[2] < riseAt[3], "R3 chain order", riseAt[2], riseAt[3]);
    end
    doOp(0, 3, "R4 chain disable");
    doOp(0, 2, "R8 disable at zero");
    doOp(1, 2, "R8 enable after rejected disable");
    doOp(0, 2, "R2 back to zero");
    doOp(1, 9, "R7 invalid index");
    doOp(1, 15, "R7 invalid index top");
    doOp(1, 1, "R5 register-less node");
    doOp(1, 7, "R5 protected child of bare node");
    doOp(0, 1, "R5 bare node count only");
    doOp(0, 7, "R5 last user");
    doOp(1, 4, "R2 sibling a");
    doOp(1, 3, "R2 sibling b");
    doOp(0, 4, "R2 shared parent stays");
    doOp(0, 3, "R4 shared parent drops");
    doOp(1, 5, "R6 protected set");
    doOp(1, 5, "R2 second user");
    doOp(0, 5, "R2 one user left");
    doOp(0, 5, "R6 protected clear");
    doOp(1, 0, "R5 root only");
    doOp(0, 0, "R5 root release");

    for (int k = 0; k < 400; k++) begin
      int n = $urandom_range(0, 9);
      bit en = 1'($urandom_range(0, 1));
      if (n < 8 && en && mcnt[n] >= 50) en = 0;
      doOp(en, n, en ? "R2 random enable" : "R2 random disable");
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule